// File: doc/BRIEF.md
# Redo Log Retirement Engine

This unit sits in a memory controller and moves committed redo logs into their home locations. It runs in the background. Each core announces the start of a transaction with a begin request and its end with a commit request. The request's bit position is the core, and therefore the transaction, identifier. The engine tracks open transactions in an active vector with one bit per core. Committed logs are queued in a list that preserves commit order.

Each core owns a log buffer at a fixed place in non-volatile memory. Its base address is `LOG_BASE + id * 2^LOG_SHIFT`. A commit supplies the number of entries in that buffer. The engine always serves the oldest committed buffer. For each entry it reads the target address word and then the data word. It then writes the data to the target address and signals that address so that a victim cache can mark a matching line as migrated. When every entry of a buffer has been written, the engine broadcasts the transaction's identifier and frees its active bit.

Top module: `redo_retire_engine`

## Requirements
- R1: While and directly after reset, `active_vec`, `commit_err`, `mem_req`, `mig_valid` and `retire_valid` are all zero.
- R2: A begin request for core i sets `active_vec[i]`, visible in the cycle after the request. A begin for a core that is already active leaves its bit set.
- R3: A commit for a core whose active bit is clear, or whose buffer is already queued, is dropped. `commit_err` is high for exactly the one cycle after that request, and no memory access, migration or retirement follows from it.
- R4: Entry k of the buffer for core i has its home address in the low `ADDR_W` bits of the word at `base(i)+2k` and its data at `base(i)+2k+1`. The engine issues a read of the address word, then a read of the data word, then one write, in that order.
- R5: For every entry the engine writes the data word to the home address. In the cycle that write is accepted, `mig_valid` is high and `mig_addr` equals the home address, once per entry.
- R6: Buffers retire strictly in commit order. When several commits arrive in the same cycle, the lower core index counts as committed first.
- R7: After the last write of a buffer is accepted, `retire_valid` pulses for one cycle with `retire_id` set to the core. The core's active bit is still set during that pulse and is clear from the next cycle on.
- R8: A commit with an entry count of zero retires without any memory access.
- R9: `commit_ready` is low only when the free list slots are fewer than the commit requests of that cycle. Ongoing migration never lowers it.
- R10: A memory request not accepted by `mem_ready` stays asserted with unchanged address, direction and write data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| begin_req | input | NUM_CORES | Begin request, one bit per core |
| commit_req | input | NUM_CORES | Commit request, one bit per core |
| commit_count | input | NUM_CORES*CNT_W | Entry count of each core's log buffer, valid with its commit bit |
| commit_ready | output | 1 | Commit requests of this cycle are taken |
| commit_err | output | 1 | One-cycle flag for a dropped commit |
| active_vec | output | NUM_CORES | Open or not yet retired transactions |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| mig_valid | output | 1 | An entry has just been migrated |
| mig_addr | output | ADDR_W | Home address of that entry |
| retire_valid | output | 1 | A buffer has been fully migrated |
| retire_id | output | ID_W | Core of the retired buffer |

## Verification
Begin and commit effects are registered once. So `active_vec` and `commit_err` are sampled on the falling edge that follows the rising edge which took the request, and `commit_err` is sampled once more a cycle later to confirm it is a single pulse. Migration results depend on how the memory stalls and have no fixed latency. Monitors on the rising edge therefore log every accepted access, every `mig_valid` and every `retire_valid`, and the bench waits on the retirement log and then compares the logged order, addresses and home memory contents. Cases that must have no effect are held for a fixed window of cycles before the logs are compared.

// File: rtl/redo_retire_pkg.sv
package redo_retire_pkg;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_RD_ADDR,
        WK_WAIT_ADDR,
        WK_RD_DATA,
        WK_WAIT_DATA,
        WK_WRITE,
        WK_RETIRE
    } walk_state_e;

    // Word offset of a core's log buffer from the log region base.
    function automatic int buf_offset(input int id, input int shift);
        return id << shift;
    endfunction

endpackage

// File: rtl/redo_retire_active.sv
module redo_retire_active #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] begin_req,
    input  logic [NUM_CORES-1:0] commit_fire,
    input  logic                 clr_valid,
    input  logic [ID_W-1:0]      clr_id,
    output logic [NUM_CORES-1:0] active,
    output logic [NUM_CORES-1:0] accept,
    output logic                 commit_err
);

    logic [NUM_CORES-1:0] active_q;
    logic [NUM_CORES-1:0] queued_q;
    logic [NUM_CORES-1:0] clr_mask;
    logic                 err_q;

    always_comb begin
        clr_mask = '0;
        if (clr_valid) clr_mask[clr_id] = 1'b1;
    end

    assign accept     = commit_fire & active_q & ~queued_q;
    assign active     = active_q;
    assign commit_err = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            queued_q <= '0;
            err_q    <= 1'b0;
        end else begin
            active_q <= (active_q & ~clr_mask) | begin_req;
            queued_q <= (queued_q & ~clr_mask) | accept;
            err_q    <= |(commit_fire & ~(active_q & ~queued_q));
        end
    end

    // R7: a queued buffer always belongs to an active transaction
    a_r7_queued_is_active: assert property (@(posedge clk) disable iff (rst)
        (queued_q & ~active_q) == '0);

    // R3: the error flag only follows a commit request
    a_r3_err_after_commit: assert property (@(posedge clk) disable iff (rst)
        commit_err |-> $past(|commit_fire));

endmodule

// File: rtl/redo_retire_fifo.sv
module redo_retire_fifo #(
    parameter int NUM_CORES = 4,
    parameter int SLOT_W    = 7
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_CORES-1:0]               push,
    input  logic [NUM_CORES-1:0][SLOT_W-1:0]   push_data,
    input  logic                               pop,
    output logic [SLOT_W-1:0]                  head,
    output logic [$clog2(NUM_CORES+1)-1:0]     count
);

    localparam int CW = $clog2(NUM_CORES + 1);

    logic [SLOT_W-1:0] slots_q [NUM_CORES];
    logic [SLOT_W-1:0] slots_d [NUM_CORES];
    logic [CW-1:0]     count_q;
    logic [CW-1:0]     count_d;

    always_comb begin
        int fill;
        slots_d = slots_q;
        fill    = int'(count_q);
        if (pop && fill != 0) begin
            for (int i = 0; i < NUM_CORES - 1; i++) slots_d[i] = slots_q[i + 1];
            fill = fill - 1;
        end
        // lower core index lands nearer the head
        for (int i = 0; i < NUM_CORES; i++) begin
            if (push[i] && fill < NUM_CORES) begin
                for (int j = 0; j < NUM_CORES; j++) begin
                    if (j == fill) slots_d[j] = push_data[i];
                end
                fill = fill + 1;
            end
        end
        count_d = CW'(fill);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            for (int i = 0; i < NUM_CORES; i++) slots_q[i] <= '0;
        end else begin
            count_q <= count_d;
            slots_q <= slots_d;
        end
    end

    assign head  = slots_q[0];
    assign count = count_q;

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(count_q) <= NUM_CORES);

    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> count_q != '0);

endmodule

// File: rtl/redo_retire_walker.sv
module redo_retire_walker
    import redo_retire_pkg::*;
#(
    parameter int ID_W      = 2,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 5,
    parameter int LOG_BASE  = 512,
    parameter int LOG_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              head_valid,
    input  logic [ID_W-1:0]   head_id,
    input  logic [CNT_W-1:0]  head_cnt,
    output logic              pop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mig_valid,
    output logic [ADDR_W-1:0] mig_addr,
    output logic              retire_valid,
    output logic [ID_W-1:0]   retire_id
);

    walk_state_e       state_q;
    logic [ID_W-1:0]   id_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] home_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] head_base;

    assign head_base = ADDR_W'(LOG_BASE + buf_offset(int'(head_id), LOG_SHIFT));

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = data_q;
        case (state_q)
            WK_RD_ADDR, WK_RD_DATA: mem_req = 1'b1;
            WK_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = home_q;
            end
            default: ;
        endcase
    end

    assign mig_valid    = (state_q == WK_WRITE) && mem_ready;
    assign mig_addr     = home_q;
    assign retire_valid = (state_q == WK_RETIRE);
    assign retire_id    = id_q;
    assign pop          = retire_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            id_q    <= '0;
            left_q  <= '0;
            ptr_q   <= '0;
            home_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                WK_IDLE: if (head_valid) begin
                    id_q    <= head_id;
                    left_q  <= head_cnt;
                    ptr_q   <= head_base;
                    state_q <= (head_cnt == '0) ? WK_RETIRE : WK_RD_ADDR;
                end
                WK_RD_ADDR: if (mem_ready) begin
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= WK_WAIT_ADDR;
                end
                WK_WAIT_ADDR: if (mem_rvalid) begin
                    home_q  <= mem_rdata[ADDR_W-1:0];
                    state_q <= WK_RD_DATA;
                end
                WK_RD_DATA: if (mem_ready) begin
                    ptr_q   <= ptr_q + 1'b1;
                    state_q <= WK_WAIT_DATA;
                end
                WK_WAIT_DATA: if (mem_rvalid) begin
                    data_q  <= mem_rdata;
                    state_q <= WK_WRITE;
                end
                WK_WRITE: if (mem_ready) begin
                    left_q  <= left_q - 1'b1;
                    state_q <= (left_q == CNT_W'(1)) ? WK_RETIRE : WK_RD_ADDR;
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    a_r8_retire_quiet: assert property (@(posedge clk) disable iff (rst)
        retire_valid |-> !mem_req);

    a_r5_mig_on_write: assert property (@(posedge clk) disable iff (rst)
        mig_valid |-> (mem_req && mem_we && mem_addr == mig_addr));

endmodule

// File: rtl/redo_retire_engine.sv
module redo_retire_engine #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 5,
    parameter int LOG_BASE  = 512,
    parameter int LOG_SHIFT = 5,
    localparam int ID_W     = $clog2(NUM_CORES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_CORES-1:0]             begin_req,
    input  logic [NUM_CORES-1:0]             commit_req,
    input  logic [NUM_CORES-1:0][CNT_W-1:0]  commit_count,
    output logic                             commit_ready,
    output logic                             commit_err,
    output logic [NUM_CORES-1:0]             active_vec,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [ADDR_W-1:0]                mem_addr,
    output logic [DATA_W-1:0]                mem_wdata,
    input  logic                             mem_ready,
    input  logic                             mem_rvalid,
    input  logic [DATA_W-1:0]                mem_rdata,
    output logic                             mig_valid,
    output logic [ADDR_W-1:0]                mig_addr,
    output logic                             retire_valid,
    output logic [ID_W-1:0]                  retire_id
);

    localparam int SLOT_W = ID_W + CNT_W;
    localparam int CW     = $clog2(NUM_CORES + 1);

    logic [NUM_CORES-1:0]             commit_fire;
    logic [NUM_CORES-1:0]             accept;
    logic [NUM_CORES-1:0][SLOT_W-1:0] slot_in;
    logic [SLOT_W-1:0]                head;
    logic [CW-1:0]                    fill;
    logic                             pop;

    always_comb begin
        commit_ready = (NUM_CORES - int'(fill)) >= $countones(commit_req);
        commit_fire  = commit_ready ? commit_req : '0;
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
        assign slot_in[i] = {ID_W'(i), commit_count[i]};
    end

    redo_retire_active #(
        .NUM_CORES (NUM_CORES),
        .ID_W      (ID_W)
    ) active_i (
        .clk         (clk),
        .rst         (rst),
        .begin_req   (begin_req),
        .commit_fire (commit_fire),
        .clr_valid   (retire_valid),
        .clr_id      (retire_id),
        .active      (active_vec),
        .accept      (accept),
        .commit_err  (commit_err)
    );

    redo_retire_fifo #(
        .NUM_CORES (NUM_CORES),
        .SLOT_W    (SLOT_W)
    ) list_i (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .push_data (slot_in),
        .pop       (pop),
        .head      (head),
        .count     (fill)
    );

    redo_retire_walker #(
        .ID_W      (ID_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .LOG_BASE  (LOG_BASE),
        .LOG_SHIFT (LOG_SHIFT)
    ) walker_i (
        .clk          (clk),
        .rst          (rst),
        .head_valid   (fill != '0),
        .head_id      (head[SLOT_W-1:CNT_W]),
        .head_cnt     (head[CNT_W-1:0]),
        .pop          (pop),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .mig_valid    (mig_valid),
        .mig_addr     (mig_addr),
        .retire_valid (retire_valid),
        .retire_id    (retire_id)
    );

    // R7: retirement happens while the transaction still counts as active
    a_r7_retire_active: assert property (@(posedge clk) disable iff (rst)
        retire_valid |-> active_vec[retire_id]);

    // R7: the bit is gone in the cycle after the broadcast
    a_r7_clear_after: assert property (@(posedge clk) disable iff (rst)
        (retire_valid && !begin_req[retire_id]) |=> !active_vec[$past(retire_id)]);

endmodule

// File: tb/redo_retire_engine_tb.sv
module redo_retire_engine_tb_top;

    localparam int N  = 4;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int CW = 5;
    localparam int LB = 512;
    localparam int LS = 5;
    localparam int IW = 2;

    // stimulus table: {core, entry count}
    localparam logic [7:0] VEC [5] = '{8'h03, 8'h21, 8'h14, 8'h32, 8'h05};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N-1:0]         begin_req = '0;
    logic [N-1:0]         commit_req = '0;
    logic [N-1:0][CW-1:0] commit_count = '0;
    logic                 commit_ready, commit_err;
    logic [N-1:0]         active_vec;
    logic                 mem_req, mem_we;
    logic [AW-1:0]        mem_addr;
    logic [DW-1:0]        mem_wdata;
    logic                 mem_ready;
    logic                 mem_rvalid;
    logic [DW-1:0]        mem_rdata;
    logic                 mig_valid;
    logic [AW-1:0]        mig_addr;
    logic                 retire_valid;
    logic [IW-1:0]        retire_id;

    redo_retire_engine #(
        .NUM_CORES (N), .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW),
        .LOG_BASE (LB), .LOG_SHIFT (LS)
    ) dut_i (
        .clk (clk), .rst (rst), .begin_req (begin_req), .commit_req (commit_req),
        .commit_count (commit_count), .commit_ready (commit_ready),
        .commit_err (commit_err), .active_vec (active_vec), .mem_req (mem_req),
        .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_ready (mem_ready), .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
        .mig_valid (mig_valid), .mig_addr (mig_addr),
        .retire_valid (retire_valid), .retire_id (retire_id)
    );

    // memory model and monitors
    logic [DW-1:0] mem [1024];
    logic          tb_wr_en = 1'b0;
    logic [AW-1:0] tb_wr_addr = '0;
    logic [DW-1:0] tb_wr_data = '0;
    logic          rv_q;
    logic [DW-1:0] rd_q;
    int            rdy_cnt = 0;
    int            acc_n, mig_n, ret_n;
    logic [AW-1:0] acc_addr [256];
    logic          acc_we   [256];
    logic [AW-1:0] mig_log  [256];
    logic [IW-1:0] ret_log  [256];

    assign mem_ready  = (rdy_cnt % 3) != 2;
    assign mem_rvalid = rv_q;
    assign mem_rdata  = rd_q;

    always @(negedge clk) rdy_cnt <= rdy_cnt + 1;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= '0;
            rv_q  <= 1'b0;
            rd_q  <= '0;
            acc_n <= 0;
            mig_n <= 0;
            ret_n <= 0;
        end else begin
            rv_q <= 1'b0;
            if (tb_wr_en) mem[tb_wr_addr] <= tb_wr_data;
            if (mem_req && mem_ready) begin
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else begin
                    rv_q <= 1'b1;
                    rd_q <= mem[mem_addr];
                end
                acc_addr[acc_n % 256] <= mem_addr;
                acc_we[acc_n % 256]   <= mem_we;
                acc_n <= acc_n + 1;
            end
            if (mig_valid) begin
                mig_log[mig_n % 256] <= mig_addr;
                mig_n <= mig_n + 1;
            end
            if (retire_valid) begin
                ret_log[ret_n % 256] <= retire_id;
                ret_n <= ret_n + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit wd_hit = 1'b0;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int home_of(input int seed, input int k);
        return (seed * 37 + k * 11 + 3) % 512;
    endfunction

    function automatic int data_of(input int seed, input int k);
        return 16'hA000 ^ (seed << 8) ^ k;
    endfunction

    function automatic int base_of(input int id);
        return LB + (id << LS);
    endfunction

    task automatic preload(input int id, input int cnt, input int seed);
        for (int k = 0; k < cnt; k++) begin
            @(negedge clk);
            tb_wr_en   = 1'b1;
            tb_wr_addr = AW'(base_of(id) + 2 * k);
            tb_wr_data = DW'(home_of(seed, k));
            @(negedge clk);
            tb_wr_addr = AW'(base_of(id) + 2 * k + 1);
            tb_wr_data = DW'(data_of(seed, k));
        end
        @(negedge clk);
        tb_wr_en = 1'b0;
    endtask

    task automatic do_begin(input logic [N-1:0] mask);
        @(negedge clk);
        begin_req = mask;
        @(negedge clk);
        begin_req = '0;
    endtask

    // returns commit_err as seen one cycle after the request
    task automatic do_commit(input logic [N-1:0] mask, input logic [N-1:0][CW-1:0] cnt,
                             output bit err);
        @(negedge clk);
        commit_req   = mask;
        commit_count = cnt;
        @(negedge clk);
        err          = commit_err;
        commit_req   = '0;
        commit_count = '0;
    endtask

    task automatic wait_retire(input int target);
        for (int t = 0; t < 3000 && ret_n < target; t++) @(negedge clk);
    endtask

    task automatic check_buf(input string req, input int seed, input int cnt, input int m0);
        for (int k = 0; k < cnt; k++) begin
            chk(req, mig_log[(m0 + k) % 256] == AW'(home_of(seed, k)),
                int'(mig_log[(m0 + k) % 256]), home_of(seed, k));
            chk(req, mem[home_of(seed, k)] == DW'(data_of(seed, k)),
                int'(mem[home_of(seed, k)]), data_of(seed, k));
        end
    endtask

    task automatic run_all();
        bit err;
        logic [N-1:0][CW-1:0] cc;
        int a0, m0, r0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 active", active_vec == '0, int'(active_vec), 0);
        chk("R1 quiet", !(mem_req || mig_valid || retire_valid || commit_err),
            int'({mem_req, mig_valid, retire_valid, commit_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", active_vec == '0 && !mem_req, int'(active_vec), 0);

        // table walk
        for (int v = 0; v < 5; v++) begin
            int id, cnt;
            id  = int'(VEC[v][7:4]);
            cnt = int'(VEC[v][3:0]);
            a0 = acc_n; m0 = mig_n; r0 = ret_n;
            do_begin(N'(1) << id);
            chk("R2 begin sets bit", active_vec[id] == 1'b1, int'(active_vec), 1 << id);
            preload(id, cnt, v);
            cc = '0; cc[id] = CW'(cnt);
            do_commit(N'(1) << id, cc, err);
            chk("R3 valid commit no error", err == 1'b0, int'(err), 0);
            chk("R9 ready while migrating", commit_ready == 1'b1, int'(commit_ready), 1);
            wait_retire(r0 + 1);
            @(negedge clk);
            chk("R7 retire id", ret_n == r0 + 1 && ret_log[r0 % 256] == IW'(id),
                int'(ret_log[r0 % 256]), id);
            chk("R7 bit cleared", active_vec[id] == 1'b0, int'(active_vec), 0);
            chk("R5 migration count", mig_n - m0 == cnt, mig_n - m0, cnt);
            check_buf("R5 home data", v, cnt, m0);
            if (v == 0) begin
                chk("R4 access count", acc_n - a0 == 3 * cnt, acc_n - a0, 3 * cnt);
                for (int k = 0; k < cnt; k++) begin
                    int p;
                    p = (a0 + 3 * k) % 256;
                    chk("R4 addr word read", !acc_we[p] && acc_addr[p] == AW'(base_of(id) + 2 * k),
                        int'(acc_addr[p]), base_of(id) + 2 * k);
                    chk("R4 data word read", !acc_we[(p + 1) % 256]
                        && acc_addr[(p + 1) % 256] == AW'(base_of(id) + 2 * k + 1),
                        int'(acc_addr[(p + 1) % 256]), base_of(id) + 2 * k + 1);
                    chk("R4 write last", acc_we[(p + 2) % 256]
                        && acc_addr[(p + 2) % 256] == AW'(home_of(0, k)),
                        int'(acc_addr[(p + 2) % 256]), home_of(0, k));
                end
            end
        end

        // R3: commit without begin
        a0 = acc_n; m0 = mig_n; r0 = ret_n;
        cc = '0; cc[1] = CW'(2);
        do_commit(4'b0010, cc, err);
        chk("R3 error on inactive", err == 1'b1, int'(err), 1);
        @(negedge clk);
        chk("R3 error one cycle", commit_err == 1'b0, int'(commit_err), 0);
        repeat (30) @(negedge clk);
        chk("R3 no effect", ret_n == r0 && mig_n == m0 && acc_n == a0 && active_vec == '0,
            ret_n - r0 + acc_n - a0, 0);

        // R6: same-cycle commits, lower index first
        r0 = ret_n; m0 = mig_n;
        do_begin(4'b1010);
        chk("R2 two begins", active_vec == 4'b1010, int'(active_vec), 10);
        preload(1, 2, 7);
        preload(3, 2, 8);
        cc = '0; cc[1] = CW'(2); cc[3] = CW'(2);
        do_commit(4'b1010, cc, err);
        chk("R6 dual commit accepted", err == 1'b0, int'(err), 0);
        wait_retire(r0 + 2);
        @(negedge clk);
        chk("R6 first retire lower index", ret_log[r0 % 256] == IW'(1), int'(ret_log[r0 % 256]), 1);
        chk("R6 second retire", ret_log[(r0 + 1) % 256] == IW'(3), int'(ret_log[(r0 + 1) % 256]), 3);
        check_buf("R6 first buffer data", 7, 2, m0);
        check_buf("R6 second buffer data", 8, 2, m0 + 2);

        // R6: commit order beats index order
        r0 = ret_n;
        do_begin(4'b0101);
        preload(0, 1, 9);
        preload(2, 1, 10);
        cc = '0; cc[2] = CW'(1);
        do_commit(4'b0100, cc, err);
        cc = '0; cc[0] = CW'(1);
        do_commit(4'b0001, cc, err);
        wait_retire(r0 + 2);
        @(negedge clk);
        chk("R6 commit order first", ret_log[r0 % 256] == IW'(2), int'(ret_log[r0 % 256]), 2);
        chk("R6 commit order second", ret_log[(r0 + 1) % 256] == IW'(0),
            int'(ret_log[(r0 + 1) % 256]), 0);

        // R3: second commit while queued
        r0 = ret_n;
        do_begin(4'b1000);
        preload(3, 3, 11);
        cc = '0; cc[3] = CW'(3);
        do_commit(4'b1000, cc, err);
        chk("R3 first commit ok", err == 1'b0, int'(err), 0);
        do_commit(4'b1000, cc, err);
        chk("R3 duplicate commit flagged", err == 1'b1, int'(err), 1);
        wait_retire(r0 + 1);
        repeat (40) @(negedge clk);
        chk("R3 duplicate not retired", ret_n == r0 + 1, ret_n - r0, 1);

        // R8: empty buffer
        r0 = ret_n; a0 = acc_n; m0 = mig_n;
        do_begin(4'b0010);
        cc = '0;
        do_commit(4'b0010, cc, err);
        wait_retire(r0 + 1);
        @(negedge clk);
        chk("R8 empty retires", ret_n == r0 + 1 && ret_log[r0 % 256] == IW'(1),
            int'(ret_log[r0 % 256]), 1);
        chk("R8 no access", acc_n == a0 && mig_n == m0, acc_n - a0, 0);
        chk("R8 bit cleared", active_vec[1] == 1'b0, int'(active_vec), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule